// File: doc/BRIEF.md
# Interrupt Flag, Enable and Vectoring Controller

This block keeps the interrupt state of a processor core for sixteen request lines: line 0 is the reset request, line 1 is the non-maskable request, lines 2 and 3 are reserved, and lines 4 to 15 are maskable. It turns rising edges on the request lines into pending flags, lets software set and clear flags indirectly, and holds the per-line enables, a sticky non-maskable enable, a global enable with its saved copy, and a relocatable vector table base.

On every cycle where the core marks an instruction boundary, the block picks the lowest-numbered pending interrupt that may be taken. It then runs the entry sequence in one clock: it clears that flag, saves and clears the global enable, stores the current program counter in the matching return pointer, and presents the vector address, a take strobe and the interrupt number. Return strobes from the core restore the global enable and, for the non-maskable case, re-arm the non-maskable enable.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset all flags are 0, the enable readout is 0x0001, global and saved global enable are 0, both return pointers are 0, and the take strobe, acknowledge and number outputs are 0.
- R2: A 0-to-1 transition on request line n sets flag bit n on the second rising clock edge after the line goes high; the flag stays set after the line falls.
- R3: A control write with select 1 (set) or select 2 (clear) sets or clears each flag bit whose data bit is 1; the flag register changes on the edge after the write edge, not on the write edge itself.
- R4: A write with select 0 loads the per-line enables of lines 4 to 15 from data bits 15:4; the enable readout always shows bit 0 as 1 and bits 2 and 3 as 0.
- R5: Data bit 1 of an enable write sets the non-maskable enable (readout bit 1); writing 0 there never clears it.
- R6: While the non-maskable enable is 0, neither line 1 nor any maskable line is taken; a pending line 0 is taken regardless of any enable.
- R7: A maskable line is taken only when the global enable (status bit 0, select 3), its own enable and the non-maskable enable are all 1, and only in a cycle where the boundary input is high; at most one interrupt is taken per boundary cycle.
- R8: When several takeable flags are pending, the lowest-numbered one is taken first.
- R9: Taking an interrupt clears its flag, copies the global enable into the saved global enable (status bit 1), clears the global enable, and for lines 4 to 15 stores the program counter input in the interrupt return pointer.
- R10: Taking line 1 stores the program counter in the non-maskable return pointer and clears the non-maskable enable; the non-maskable return strobe sets it again and copies the saved global enable into the global enable.
- R11: The vector address is data bits 31:10 of the last table write (select 4), with bits 9:0 zero, plus the interrupt number times 32.
- R12: In the cycle after a take edge, the take strobe and acknowledge are high for that cycle and the number output holds the taken interrupt number in binary.
- R13: The maskable return strobe copies the saved global enable into the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_line | input | 16 | Interrupt request lines, active high, edge recognised |
| pc_in | input | 32 | Return address to save when an interrupt is taken |
| boundary | input | 1 | High in cycles where an interrupt may be taken |
| ret_irq | input | 1 | Return-from-maskable strobe |
| ret_nmi | input | 1 | Return-from-non-maskable strobe |
| cr_we | input | 1 | Control register write strobe |
| cr_sel | input | 3 | Write select: 0 enable, 1 flag set, 2 flag clear, 3 status, 4 table base |
| cr_wdata | input | 32 | Control register write data |
| flag_o | output | 16 | Pending flag register |
| ena_o | output | 16 | Enable readout |
| gie_o | output | 1 | Global enable |
| pgie_o | output | 1 | Saved global enable |
| irp_o | output | 32 | Interrupt return pointer |
| nrp_o | output | 32 | Non-maskable return pointer |
| pc_load_o | output | 1 | Take strobe: load the program counter from pc_next_o |
| pc_next_o | output | 32 | Vector address of the taken interrupt |
| iack_o | output | 1 | Interrupt acknowledge pulse |
| inum_o | output | 4 | Number of the taken interrupt |

## Verification
Enable, status and table writes appear on the outputs right after their write edge, set and clear writes one edge later, and a request line edge reaches the flag after two edges; the bench drives on falling edges and samples flags exactly at those points, including a sample between the write edge and the apply edge for set and clear. A take decided at a boundary edge shows the strobe, vector, number, return pointer and cleared global enable in the following cycle, so each take check is sampled right after that single edge. Refusals are checked by observing that no take strobe appears and that the flag remains pending.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int unsigned IRQ_LINES      = 16;
    localparam int unsigned ADDR_BITS      = 32;
    localparam int unsigned TBASE_LSB      = 10;
    localparam int unsigned SLOT_LSB       = 5;
    localparam int unsigned FIRST_MASKABLE = 4;
    localparam int unsigned RESET_IDX      = 0;
    localparam int unsigned NMI_IDX        = 1;
    localparam int unsigned IDX_BITS       = $clog2(IRQ_LINES);

    typedef enum logic [2:0] {
        CR_ENABLE   = 3'd0,
        CR_FLAG_SET = 3'd1,
        CR_FLAG_CLR = 3'd2,
        CR_STATUS   = 3'd3,
        CR_TABLE    = 3'd4
    } cr_sel_e;

    typedef struct packed {
        logic [IRQ_LINES-1:FIRST_MASKABLE] ena;
        logic                              nmie;
        logic                              gie;
        logic                              pgie;
        logic [ADDR_BITS-1:TBASE_LSB]      tbase;
        logic [ADDR_BITS-1:0]              irp;
        logic [ADDR_BITS-1:0]              nrp;
        logic [ADDR_BITS-1:0]              pc_next;
        logic                              take;
        logic [IDX_BITS-1:0]               inum;
    } ctrl_state_t;

endpackage

// File: rtl/irqv_flag_bank.sv
module irqv_flag_bank #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_i,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] take_clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] line_d, line_q;
    logic [N-1:0] line_dd, line_qq;
    logic [N-1:0] pset_d, pset_q;
    logic [N-1:0] pclr_d, pclr_q;
    logic [N-1:0] flag_d, flag_q;
    logic [N-1:0] rise;

    // first stage latches the lines, second stage finds the 0-to-1 step
    always_comb begin
        line_d  = line_i;
        line_dd = line_q;
        rise    = line_q & ~line_qq;
        pset_d  = set_i;
        pclr_d  = clr_i;
        flag_d  = (flag_q | rise | pset_q) & ~pclr_q & ~take_clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q  <= '0;
            line_qq <= '0;
            pset_q  <= '0;
            pclr_q  <= '0;
            flag_q  <= '0;
        end else begin
            line_q  <= line_d;
            line_qq <= line_dd;
            pset_q  <= pset_d;
            pclr_q  <= pclr_d;
            flag_q  <= flag_d;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/irqv_prio_pick.sv
module irqv_prio_pick #(
    parameter int unsigned N  = 16,
    parameter int unsigned IW = 4
) (
    input  logic [N-1:0]  cand_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // scan from the top so the lowest set index is the last one written
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) idx_o = IW'(i);
        end
        any_o = |cand_i;
    end
endmodule

// File: rtl/irqv_vec_gen.sv
module irqv_vec_gen #(
    parameter int unsigned AW   = 32,
    parameter int unsigned TLSB = 10,
    parameter int unsigned SLSB = 5,
    parameter int unsigned IW   = 4
) (
    input  logic [AW-1:TLSB] tbase_i,
    input  logic [IW-1:0]    idx_i,
    output logic [AW-1:0]    vec_o
);
    logic [AW-1:0] base_full;
    logic [AW-1:0] slot_off;

    always_comb begin
        base_full = {tbase_i, {TLSB{1'b0}}};
        slot_off  = AW'(idx_i) << SLSB;
        vec_o     = base_full + slot_off;
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int unsigned N    = IRQ_LINES,
    parameter int unsigned AW   = ADDR_BITS,
    parameter int unsigned TLSB = TBASE_LSB,
    parameter int unsigned SLSB = SLOT_LSB,
    parameter int unsigned IW   = IDX_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_line,
    input  logic [AW-1:0] pc_in,
    input  logic          boundary,
    input  logic          ret_irq,
    input  logic          ret_nmi,
    input  logic          cr_we,
    input  logic [2:0]    cr_sel,
    input  logic [AW-1:0] cr_wdata,
    output logic [N-1:0]  flag_o,
    output logic [N-1:0]  ena_o,
    output logic          gie_o,
    output logic          pgie_o,
    output logic [AW-1:0] irp_o,
    output logic [AW-1:0] nrp_o,
    output logic          pc_load_o,
    output logic [AW-1:0] pc_next_o,
    output logic          iack_o,
    output logic [IW-1:0] inum_o
);
    localparam int unsigned FM = FIRST_MASKABLE;

    ctrl_state_t   st_d, st_q;
    logic [N-1:0]  flags;
    logic [N-1:0]  cand;
    logic [N-1:0]  set_req, clr_req, take_clr;
    logic          pick_any;
    logic [IW-1:0] pick_idx;
    logic [AW-1:0] vec_addr;
    logic          take_now;
    cr_sel_e       sel;

    assign sel      = cr_sel_e'(cr_sel);
    assign set_req  = (cr_we && sel == CR_FLAG_SET) ? cr_wdata[N-1:0] : '0;
    assign clr_req  = (cr_we && sel == CR_FLAG_CLR) ? cr_wdata[N-1:0] : '0;
    assign take_now = boundary && pick_any;

    always_comb begin
        take_clr = '0;
        if (take_now) take_clr[pick_idx] = 1'b1;
    end

    irqv_flag_bank #(.N(N)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (irq_line),
        .set_i      (set_req),
        .clr_i      (clr_req),
        .take_clr_i (take_clr),
        .flag_o     (flags)
    );

    // which flags may be taken, and how the enable readout looks, per line class
    for (genvar g = 0; g < N; g++) begin : g_line
        if (g == RESET_IDX) begin : g_rst
            assign cand[g]  = flags[g];
            assign ena_o[g] = 1'b1;
        end else if (g == NMI_IDX) begin : g_nmi
            assign cand[g]  = flags[g] & st_q.nmie;
            assign ena_o[g] = st_q.nmie;
        end else if (g < FM) begin : g_rsv
            assign cand[g]  = 1'b0;
            assign ena_o[g] = 1'b0;
        end else begin : g_mask
            assign cand[g]  = flags[g] & st_q.ena[g] & st_q.gie & st_q.nmie;
            assign ena_o[g] = st_q.ena[g];
        end
    end

    irqv_prio_pick #(.N(N), .IW(IW)) u_pick (
        .cand_i (cand),
        .any_o  (pick_any),
        .idx_o  (pick_idx)
    );

    irqv_vec_gen #(.AW(AW), .TLSB(TLSB), .SLSB(SLSB), .IW(IW)) u_vec (
        .tbase_i (st_q.tbase),
        .idx_i   (pick_idx),
        .vec_o   (vec_addr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;

        // software writes have the lowest precedence
        if (cr_we) begin
            case (sel)
                CR_ENABLE: begin
                    st_d.ena = cr_wdata[N-1:FM];
                    if (cr_wdata[NMI_IDX]) st_d.nmie = 1'b1;
                end
                CR_STATUS: begin
                    st_d.gie  = cr_wdata[0];
                    st_d.pgie = cr_wdata[1];
                end
                CR_TABLE: st_d.tbase = cr_wdata[AW-1:TLSB];
                default: ;
            endcase
        end

        if (ret_irq) st_d.gie = st_q.pgie;
        if (ret_nmi) begin
            st_d.gie  = st_q.pgie;
            st_d.nmie = 1'b1;
        end

        // the entry sequence overrides everything else in the same cycle
        if (take_now) begin
            st_d.take    = 1'b1;
            st_d.inum    = pick_idx;
            st_d.pc_next = vec_addr;
            st_d.pgie    = st_q.gie;
            st_d.gie     = 1'b0;
            if (pick_idx == IW'(NMI_IDX)) begin
                st_d.nrp  = pc_in;
                st_d.nmie = 1'b0;
            end else if (pick_idx != IW'(RESET_IDX)) begin
                st_d.irp = pc_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o    = flags;
    assign gie_o     = st_q.gie;
    assign pgie_o    = st_q.pgie;
    assign irp_o     = st_q.irp;
    assign nrp_o     = st_q.nrp;
    assign pc_load_o = st_q.take;
    assign iack_o    = st_q.take;
    assign pc_next_o = st_q.pc_next;
    assign inum_o    = st_q.inum;
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
    parameter int unsigned N    = 16,
    parameter int unsigned AW   = 32,
    parameter int unsigned SLSB = 5,
    parameter int unsigned IW   = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          boundary,
    input logic          pc_load_o,
    input logic          iack_o,
    input logic [IW-1:0] inum_o,
    input logic [AW-1:0] pc_next_o,
    input logic [N-1:0]  ena_o,
    input logic          gie_o
);
    // R7: a take only follows a boundary cycle
    a_r7_take_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> $past(boundary));

    // R9: the cycle after a take sees the global enable cleared
    a_r9_gie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> !gie_o);

    // R5, R10: the non-maskable enable only drops through a line 1 entry
    a_r5_nmie_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ena_o[1]) |-> (pc_load_o && inum_o == IW'(1)));

    // R6: a maskable take requires the non-maskable enable to have been set
    a_r6_maskable_needs_nmie: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load_o && inum_o >= IW'(4)) |-> $past(ena_o[1]));

    // R11: the vector lands on the slot of the taken number
    a_r11_slot_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> (pc_next_o[SLSB-1:0] == '0 && pc_next_o[SLSB +: IW] == inum_o));

    // R12: acknowledge and take strobe travel together
    a_r12_ack_with_take: assert property (@(posedge clk) disable iff (!rst_n)
        iack_o == pc_load_o);

    // R4: fixed bits of the enable readout
    a_r4_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        ena_o[0] && ena_o[3:2] == 2'b00);
endmodule

bind irq_vector_ctrl irqv_checker #(.N(N), .AW(AW), .SLSB(SLSB), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .boundary  (boundary),
    .pc_load_o (pc_load_o),
    .iack_o    (iack_o),
    .inum_o    (inum_o),
    .pc_next_o (pc_next_o),
    .ena_o     (ena_o),
    .gie_o     (gie_o)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_line = '0;
    logic [31:0] pc_in = '0;
    logic        boundary = 1'b0;
    logic        ret_irq = 1'b0;
    logic        ret_nmi = 1'b0;
    logic        cr_we = 1'b0;
    logic [2:0]  cr_sel = '0;
    logic [31:0] cr_wdata = '0;
    logic [15:0] flag_o, ena_o;
    logic        gie_o, pgie_o, pc_load_o, iack_o;
    logic [31:0] irp_o, nrp_o, pc_next_o;
    logic [3:0]  inum_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .pc_in(pc_in),
        .boundary(boundary), .ret_irq(ret_irq), .ret_nmi(ret_nmi),
        .cr_we(cr_we), .cr_sel(cr_sel), .cr_wdata(cr_wdata),
        .flag_o(flag_o), .ena_o(ena_o), .gie_o(gie_o), .pgie_o(pgie_o),
        .irp_o(irp_o), .nrp_o(nrp_o), .pc_load_o(pc_load_o),
        .pc_next_o(pc_next_o), .iack_o(iack_o), .inum_o(inum_o)
    );

    typedef struct packed {
        logic [3:0]  num;
        logic [15:0] mask;
        logic        gie;
        logic        take;
        logic [31:0] base;
        logic [31:0] vec;
    } row_t;

    localparam row_t TBL [6] = '{
        '{4'd7,  16'h0080, 1'b1, 1'b1, 32'h0000_0800, 32'h0000_08E0},
        '{4'd4,  16'h0010, 1'b1, 1'b1, 32'h0000_0000, 32'h0000_0080},
        '{4'd15, 16'h8000, 1'b1, 1'b1, 32'h1234_5C00, 32'h1234_5DE0},
        '{4'd9,  16'h0400, 1'b1, 1'b0, 32'h0000_0800, 32'h0000_0000},
        '{4'd10, 16'h0400, 1'b0, 1'b0, 32'h0000_0800, 32'h0000_0000},
        '{4'd12, 16'h1000, 1'b1, 1'b1, 32'hFFFF_FC00, 32'hFFFF_FD80}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic cr_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cr_we = 1'b1; cr_sel = sel; cr_wdata = data;
        @(negedge clk);
        cr_we = 1'b0;
    endtask

    task automatic pulse_line(input int n);
        @(negedge clk); irq_line[n] = 1'b1;
        @(negedge clk); irq_line[n] = 1'b0;
        @(negedge clk);
    endtask

    task automatic at_boundary(input logic [31:0] pc);
        @(negedge clk); pc_in = pc; boundary = 1'b1;
        @(negedge clk); boundary = 1'b0;
    endtask

    task automatic clear_all();
        cr_write(3'd2, 32'h0000_FFFF);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 flags", 32'(flag_o), 32'h0);
        chk("R1 enables", 32'(ena_o), 32'h1);
        chk("R1 gie/pgie", {30'd0, gie_o, pgie_o}, 32'h0);
        chk("R1 strobes", {28'd0, pc_load_o, iack_o, 2'b0}, 32'h0);
        chk("R1 inum", 32'(inum_o), 32'h0);
        chk("R1 irp", irp_o, 32'h0);

        // R6: no non-maskable enable, maskable line not taken
        cr_write(3'd4, 32'h0000_2000);
        cr_write(3'd0, 32'h0000_0080);
        cr_write(3'd3, 32'h0000_0001);
        cr_write(3'd1, 32'h0000_0080);
        @(negedge clk);
        at_boundary(32'h100);
        chk("R6 blocked take", 32'(pc_load_o), 32'h0);
        chk("R6 flag kept", 32'(flag_o), 32'h80);

        // R4 readout, then R7 take once enabled (no boundary first)
        cr_write(3'd0, 32'h0000_0082);
        chk("R4 readout", 32'(ena_o), 32'h0083);
        repeat (3) @(negedge clk);
        chk("R7 no boundary no take", 32'(pc_load_o), 32'h0);
        at_boundary(32'h0000_0104);
        chk("R7 take", 32'(pc_load_o), 32'h1);
        chk("R12 inum 7", 32'(inum_o), 32'h7);
        chk("R11 vector", pc_next_o, 32'h0000_20E0);
        chk("R9 irp", irp_o, 32'h0000_0104);
        chk("R9 flag cleared", 32'(flag_o), 32'h0);
        chk("R9 gie/pgie", {30'd0, gie_o, pgie_o}, 32'h1);
        @(negedge clk);
        chk("R12 single pulse", {31'd0, pc_load_o | iack_o}, 32'h0);

        // R5 sticky
        cr_write(3'd0, 32'h0000_0000);
        chk("R5 nmie sticky", 32'(ena_o), 32'h0003);

        // R3 timing of set and clear
        cr_write(3'd1, 32'h0000_0180);
        chk("R3 set not yet", 32'(flag_o), 32'h0);
        @(negedge clk);
        chk("R3 set applied", 32'(flag_o), 32'h0180);
        cr_write(3'd2, 32'h0000_0180);
        chk("R3 clear not yet", 32'(flag_o), 32'h0180);
        @(negedge clk);
        chk("R3 clear applied", 32'(flag_o), 32'h0);

        // table walk: R2 R7 R9 R11 R12
        for (int i = 0; i < 6; i++) begin
            cr_write(3'd0, 32'(TBL[i].mask | 16'h0002));
            cr_write(3'd4, TBL[i].base);
            cr_write(3'd3, {31'd0, TBL[i].gie});
            pulse_line(int'(TBL[i].num));
            chk("R2 flag from line", 32'(flag_o), 32'(16'h1 << TBL[i].num));
            at_boundary(32'h1000 + 32'(TBL[i].num) * 4);
            chk("R7 take decision", 32'(pc_load_o), 32'(TBL[i].take));
            if (TBL[i].take) begin
                chk("R12 inum", 32'(inum_o), 32'(TBL[i].num));
                chk("R11 vector", pc_next_o, TBL[i].vec);
                chk("R9 irp", irp_o, 32'h1000 + 32'(TBL[i].num) * 4);
                chk("R9 flag cleared", 32'(flag_o), 32'h0);
                chk("R9 gie/pgie", {30'd0, gie_o, pgie_o}, 32'h1);
            end else begin
                chk("R7 flag pending", 32'(flag_o), 32'(16'h1 << TBL[i].num));
            end
            clear_all();
        end

        // R8 priority and R13 return
        cr_write(3'd4, 32'h0000_2000);
        cr_write(3'd0, 32'h0000_0232);
        cr_write(3'd3, 32'h0000_0001);
        cr_write(3'd1, 32'h0000_0220);
        @(negedge clk);
        at_boundary(32'h0000_3000);
        chk("R8 lowest first", 32'(inum_o), 32'h5);
        chk("R11 vector 5", pc_next_o, 32'h0000_20A0);
        chk("R7 one per boundary", 32'(flag_o), 32'h0200);
        @(negedge clk); ret_irq = 1'b1;
        @(negedge clk); ret_irq = 1'b0;
        chk("R13 gie restored", 32'(gie_o), 32'h1);
        at_boundary(32'h0000_3010);
        chk("R8 next taken", 32'(inum_o), 32'h9);
        chk("R9 irp second", irp_o, 32'h0000_3010);
        clear_all();

        // R10 non-maskable entry and return
        cr_write(3'd3, 32'h0000_0001);
        cr_write(3'd1, 32'h0000_0002);
        @(negedge clk);
        at_boundary(32'h0000_4444);
        chk("R10 inum 1", 32'(inum_o), 32'h1);
        chk("R10 nrp", nrp_o, 32'h0000_4444);
        chk("R10 irp untouched", irp_o, 32'h0000_3010);
        chk("R11 vector nmi", pc_next_o, 32'h0000_2020);
        chk("R10 nmie cleared", 32'(ena_o[1]), 32'h0);
        cr_write(3'd3, 32'h0000_0003);
        cr_write(3'd1, 32'h0000_0010);
        @(negedge clk);
        at_boundary(32'h0000_5000);
        chk("R10 maskable blocked", 32'(pc_load_o), 32'h0);
        @(negedge clk); ret_nmi = 1'b1;
        @(negedge clk); ret_nmi = 1'b0;
        chk("R10 nmie restored", 32'(ena_o[1]), 32'h1);
        chk("R10 gie restored", 32'(gie_o), 32'h1);
        at_boundary(32'h0000_5004);
        chk("R10 maskable after return", 32'(inum_o), 32'h4);
        chk("R10 take after return", 32'(pc_load_o), 32'h1);
        clear_all();

        // R6 reset line ignores all enables
        cr_write(3'd3, 32'h0000_0000);
        cr_write(3'd1, 32'h0000_0001);
        @(negedge clk);
        at_boundary(32'h0000_6000);
        chk("R6 reset taken", 32'(pc_load_o), 32'h1);
        chk("R6 reset inum", 32'(inum_o), 32'h0);
        chk("R11 reset vector", pc_next_o, 32'h0000_2000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule